// File: doc/BRIEF.md
# Write-Port Slot Reservation Issue Scoreboard

This block is the issue-control gate for a pipeline that forks after register read into three execution paths of different depth: a single-cycle ALU, a pipelined multiplier and a divider that cannot accept new operands while it works. All three paths share one register-file write port. Decoded instructions arrive one at a time, each carrying an operation class and a destination register. The block decides each cycle whether the instruction at its input may issue.

An instruction is held when any of three conditions applies. The write-port cycle it would need is already booked. A previously issued instruction to the same destination would complete no earlier than it would. Or it is a divide and the divider is still occupied. The conditions are ORed. A timeline of future write-port cycles shifts by one position each clock. Each register carries a countdown to its latest booked write. The block also announces, in the cycle each booked write lands, that a result is being written and to which register.

The decode input is a valid/ready stream. `in_ready` depends only on the class and destination presented and on internal state, never on `in_valid`. An instruction issues on a clock edge where both are high. While `in_ready` is low the producer must hold the same instruction. Nothing is recorded for a cycle without an issue. The writeback announcement and the divider-busy flag are plain status outputs with no handshake.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset `wb_valid` and `div_busy` are low, and any instruction presented is ready, because no write, no register countdown and no divide is pending.
- R2: Class code 0 is ALU with latency 1, code 1 is multiply with latency 4, code 2 is divide with latency 12, and code 3 behaves as ALU. An instruction that issues in cycle t gives `wb_valid` high with `wb_rd` equal to its destination in cycle t+latency.
- R3: An instruction whose write cycle t+latency is already booked by an earlier issue is held (`in_ready` low).
- R4: An instruction is held when an earlier issue to the same destination register will write in cycle t+latency or later, so writes to one register land in issue order.
- R5: After a divide issues in cycle t, `div_busy` is high in cycles t+1 through t+11, any divide presented in those cycles is held, and a divide is again accepted from cycle t+12 if no other condition holds. `div_busy` never blocks non-divide classes.
- R6: `in_ready` does not depend on `in_valid`, and a cycle with `in_valid` low books nothing: no later `wb_valid`, no register countdown and no divider occupancy result from it.
- R7: When none of the R3, R4 or R5 conditions holds, `in_ready` is high, so a held instruction issues in the first cycle its conditions clear, and at most one instruction issues per cycle.
- R8: A held instruction books nothing, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction may issue this cycle |
| in_cls | input | 2 | Operation class (0 ALU, 1 multiply, 2 divide, 3 as ALU) |
| in_rd | input | $clog2(NREG) | Destination register |
| wb_valid | output | 1 | A booked write lands this cycle |
| wb_rd | output | $clog2(NREG) | Register written this cycle |
| div_busy | output | 1 | Divider occupied by an earlier divide |

## Verification
The bench builds the block with NREG = 4 and the default latencies of 1, 4 and 12 cycles. With only four registers, every pairing of two instructions can be swept: each class, the same or a different destination, and every issue gap from 0 to 13 cycles. That sweep reaches every write-port clash, every same-register overtaking case and both edges of the divider window. A dense pseudo-random stream over the same four registers then stacks all three stall causes together, while an arithmetic model of absolute write cycles predicts `in_ready`, `wb_valid`, `wb_rd` and `div_busy` every cycle.

// File: rtl/isb_pkg.sv
package isb_pkg;
  typedef enum logic [1:0] {
    OP_ALU = 2'd0,
    OP_MUL = 2'd1,
    OP_DIV = 2'd2,
    OP_RSV = 2'd3
  } op_cls_e;
endpackage

// File: rtl/isb_wport_timeline.sv
module isb_wport_timeline #(
  parameter int DEPTH = 12,
  parameter int RW    = 5,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          book,
  input  logic [LW-1:0] book_lat,
  input  logic [RW-1:0] book_rd,
  input  logic [LW-1:0] query_lat,
  output logic          query_busy,
  output logic          wb_valid,
  output logic [RW-1:0] wb_rd
);
  // slot j describes the write landing j cycles after the current one
  logic          slot_v  [DEPTH];
  logic [RW-1:0] slot_rd [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic          nxt_v;
    logic [RW-1:0] nxt_rd;
    always_comb begin
      if (j < DEPTH - 1) begin
        nxt_v  = slot_v[(j < DEPTH - 1) ? j + 1 : j];
        nxt_rd = slot_rd[(j < DEPTH - 1) ? j + 1 : j];
      end else begin
        nxt_v  = 1'b0;
        nxt_rd = '0;
      end
      if (book && book_lat == LW'(j + 1)) begin
        nxt_v  = 1'b1;
        nxt_rd = book_rd;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[j]  <= 1'b0;
        slot_rd[j] <= '0;
      end else begin
        slot_v[j]  <= nxt_v;
        slot_rd[j] <= nxt_rd;
      end
    end
  end

  always_comb begin
    query_busy = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (query_lat == LW'(j)) query_busy = slot_v[j];
    end
  end

  assign wb_valid = slot_v[0];
  assign wb_rd    = slot_rd[0];

  // R2: a one-cycle booking shows up on the write port at the next cycle
  p_short_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (book && book_lat == LW'(1)) |=> (wb_valid && wb_rd == $past(book_rd)));

  // R3: a booking never lands on a slot that is already occupied
  p_no_rebook_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (book && query_lat == book_lat) |-> !query_busy);
endmodule

// File: rtl/isb_reg_pending.sv
module isb_reg_pending #(
  parameter int NREG = 32,
  parameter int RW   = 5,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [RW-1:0] set_rd,
  input  logic [CW-1:0] set_cnt,
  input  logic [RW-1:0] chk_rd,
  input  logic [CW-1:0] chk_lat,
  output logic          waw_hit
);
  logic [CW-1:0] cnt [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit_me;
    assign hit_me = set && (set_rd == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt[r] <= '0;
      else if (hit_me)         cnt[r] <= set_cnt;
      else if (cnt[r] != '0)   cnt[r] <= cnt[r] - 1'b1;
    end

    // R4: an untouched countdown falls by exactly one per cycle
    p_cnt_decay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[r] != '0 && !hit_me) |=> (cnt[r] == $past(cnt[r]) - 1'b1));
  end

  // pending write lands at now+cnt; a new write at now+lat must be strictly later
  assign waw_hit = (cnt[chk_rd] >= chk_lat);
endmodule

// File: rtl/isb_div_track.sv
module isb_div_track #(
  parameter int OCC = 12,
  parameter int DW  = $clog2(OCC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [DW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (start)        left <= DW'(OCC - 1);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy = (left != '0);

  // R5: occupancy drains one step per cycle once started
  p_div_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (left == $past(left) - 1'b1));

  // R5: a new divide never starts while the divider is occupied
  p_div_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int NREG    = 32,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 4,
  parameter int LAT_DIV = 12,
  parameter int DIV_OCC = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_cls,
  input  logic [$clog2(NREG)-1:0] in_rd,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_rd,
  output logic                    div_busy
);
  import isb_pkg::*;

  localparam int RW    = $clog2(NREG);
  localparam int MAXMD = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int DEPTH = (LAT_ALU > MAXMD) ? LAT_ALU : MAXMD;
  localparam int LW    = $clog2(DEPTH + 1);

  op_cls_e       cls;
  logic [LW-1:0] lat;
  logic          is_div;
  logic          port_clash;
  logic          waw_hit;
  logic          div_block;
  logic          issue;

  assign cls = op_cls_e'(in_cls);

  always_comb begin
    unique case (cls)
      OP_MUL:  lat = LW'(LAT_MUL);
      OP_DIV:  lat = LW'(LAT_DIV);
      default: lat = LW'(LAT_ALU);
    endcase
  end

  assign is_div    = (cls == OP_DIV);
  assign div_block = is_div && div_busy;
  assign in_ready  = !(port_clash || waw_hit || div_block);
  assign issue     = in_valid && in_ready;

  isb_wport_timeline #(.DEPTH(DEPTH), .RW(RW), .LW(LW)) u_tl (
    .clk        (clk),
    .rst_n      (rst_n),
    .book       (issue),
    .book_lat   (lat),
    .book_rd    (in_rd),
    .query_lat  (lat),
    .query_busy (port_clash),
    .wb_valid   (wb_valid),
    .wb_rd      (wb_rd)
  );

  isb_reg_pending #(.NREG(NREG), .RW(RW), .CW(LW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (issue),
    .set_rd  (in_rd),
    .set_cnt (lat - 1'b1),
    .chk_rd  (in_rd),
    .chk_lat (lat),
    .waw_hit (waw_hit)
  );

  isb_div_track #(.OCC(DIV_OCC)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (issue && is_div),
    .busy  (div_busy)
  );

  // R3: a booked write-port cycle holds the instruction
  p_clash_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    port_clash |-> !in_ready);

  // R4: a pending same-register write that would be overtaken holds the instruction
  p_waw_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    waw_hit |-> !in_ready);

  // R5: a divide is never accepted while the divider is occupied
  p_div_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && in_cls == 2'd2) |-> !in_ready);

  // R7: with every stall source quiet the instruction is accepted
  p_clear_accepts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_clash && !waw_hit && !div_busy) |-> in_ready);
endmodule

// File: tb/sim_issue_scoreboard.sv
module sim_issue_scoreboard;
  localparam int NREG = 4;
  localparam int RW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_cls = 2'd0;
  logic [RW-1:0] in_rd = '0;
  logic          wb_valid;
  logic [RW-1:0] wb_rd;
  logic          div_busy;

  always #2 clk = ~clk;  // 250 MHz

  issue_scoreboard #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_rd(in_rd), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .div_busy(div_busy)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // arithmetic model in absolute cycle numbers
  int cyc = 0;
  bit pb  [64];
  int prd [64];
  int lastw [NREG];
  int divfree = 0;

  function automatic int lat_of(input logic [1:0] c);
    if (c == 2'd1) return 4;
    if (c == 2'd2) return 12;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic [RW-1:0] r,
                      output bit acc);
    int L, slot;
    bit clash, waw, dv, er;
    string why;
    @(negedge clk);
    in_valid = v; in_cls = c; in_rd = r;
    #1;
    L = lat_of(c);
    clash = pb[(cyc + L) % 64];
    waw   = (lastw[r] >= cyc + L);
    dv    = (c == 2'd2) && (cyc < divfree);
    er    = !(clash || waw || dv);
    if (clash)    why = "R3";
    else if (waw) why = "R4";
    else if (dv)  why = "R5";
    else          why = "R7";
    chk(in_ready == er, why, in_ready, er);
    slot = cyc % 64;
    chk(wb_valid == pb[slot], "R2", wb_valid, pb[slot]);
    if (pb[slot]) chk(wb_rd == RW'(prd[slot]), "R2", wb_rd, prd[slot]);
    chk(div_busy == (cyc < divfree), "R5", div_busy, (cyc < divfree));
    pb[slot] = 1'b0;
    acc = v && er;
    if (acc) begin
      pb[(cyc + L) % 64]  = 1'b1;
      prd[(cyc + L) % 64] = r;
      lastw[r] = cyc + L;
      if (c == 2'd2) divfree = cyc + 12;
    end
    @(posedge clk);
    cyc++;
  endtask

  task automatic push(input logic [1:0] c, input logic [RW-1:0] r);
    bit a;
    a = 1'b0;
    for (int k = 0; k < 40 && !a; k++) step(1'b1, c, r, a);
    if (!a) chk(1'b0, "R7", 0, 1);
  endtask

  task automatic idle(input int n);
    bit a;
    // valid low with varied class: R6, nothing may be booked
    for (int k = 0; k < n; k++) step(1'b0, 2'(k), RW'(k), a);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin pb[i] = 1'b0; prd[i] = 0; end
    for (int i = 0; i < NREG; i++) lastw[i] = -1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int c = 0; c < 4; c++) begin
      in_cls = 2'(c); #1;
      chk(in_ready == 1'b1, "R1", in_ready, 1);
      chk(wb_valid == 1'b0, "R1", wb_valid, 0);
      chk(div_busy == 1'b0, "R1", div_busy, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // pair sweep: every class pair, same/different register, gaps 0..13
    for (int a = 0; a < 4; a++)
      for (int ra = 0; ra < 2; ra++)
        for (int b = 0; b < 4; b++)
          for (int rb = 0; rb < 2; rb++)
            for (int g = 0; g < 14; g++) begin
              push(2'(a), RW'(ra));
              idle(g);
              push(2'(b), RW'(rb));
              idle(14);
            end

    // dense stream, held instruction kept while not ready (R8)
    begin
      logic [15:0] lf;
      logic [1:0]  c;
      logic [RW-1:0] r;
      logic v;
      bit a, hold;
      lf = 16'hACE1; hold = 1'b0; c = 0; r = 0; v = 0;
      for (int k = 0; k < 20000; k++) begin
        if (!hold) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          v = (lf[1:0] != 2'b00);
          c = lf[4:3];
          r = RW'(lf[7:6]);
        end
        step(v, c, r, a);
        hold = v && !a;
      end
    end
    idle(14);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule